// File: doc/BRIEF.md
# Push-Pull PWM Steering Controller

This block is a fixed-frequency digital pulse-width modulator for two-switch power stages. A free-running ramp counter sets the switching period. For the first few cycles of every period it raises an oscillator pulse. A digital control level stands in for an error-amplifier voltage and is compared against the ramp to form one modulated pulse per period. A toggle flip-flop advances at every ramp restart and sends successive pulses to output A and output B in turn. Each output therefore switches at half the oscillator rate, and the OR of the two runs at the full rate for single-ended use.

The oscillator pulse is also a blanking window: both outputs are held off while it is high. This keeps a dead time between the two switches and caps each output's duty below one half. A current-limit flag and a shutdown flag override the control level. Either one ends the active pulse at once and keeps it ended until the next period begins.

A sync input restarts the ramp on its rising edge. The oscillator pulse output can drive a shared sync line. The unit programmed with the shortest period then paces every unit whose period is set somewhat longer. Period, blanking width and control level are captured only when the ramp restarts, so a setting change never splits or stretches a pulse.

Top module: `pp_pwm_steer`

## Requirements
- R1: The ramp counts 0, 1, … P and then restarts at 0, where P is the captured period setting, giving P+1 clock cycles per period. `osc_o` is high exactly while the ramp value is below the captured blanking width B.
- R2: Each ramp restart toggles the steering flip-flop. The first period after reset goes to `out_a`, and later periods alternate between `out_b` and `out_a`.
- R3: While `osc_o` is high, both outputs are low. `out_a` and `out_b` are never high in the same cycle.
- R4: In a period free of overrides, the selected output is high in the cycles where B <= ramp < L, with L the captured control level. That is max(0, min(L, P+1) − B) cycles, so L <= B gives no pulse, and a larger L gives a wider pulse up to the blanking limit.
- R5: `period_i`, `blank_i` and `level_i` are captured only in the last cycle of a period, or on a sync restart. Changes at any other time do not affect the period in progress.
- R6: In any cycle where `ilim_i` or `shdn_i` is high, both outputs are low in that same cycle.
- R7: After `ilim_i` or `shdn_i` has been high in a cycle that does not end the period, both outputs stay low for the rest of that period. Normal output resumes in the next period.
- R8: A rising edge on `sync_i` restarts the ramp. The counter is 0 in the next cycle, and the steering flip-flop toggles and the settings are captured just as at a normal restart. A level held high causes only one restart.
- R9: While `rst` is high, `out_a`, `out_b` and `osc_o` are low in the same cycle. The reset is synchronous: after a clock edge with `rst` high, the ramp is at 0 and the captured settings are 0. The first cycle after reset ends that initial period and captures the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Ramp terminal value P; the period is P+1 cycles |
| blank_i | input | CNT_W | Blanking and oscillator pulse width B in cycles |
| level_i | input | CNT_W | Control level L compared against the ramp |
| ilim_i | input | 1 | Current-limit flag; overrides the control level |
| shdn_i | input | 1 | Shutdown flag; overrides the control level |
| sync_i | input | 1 | External sync; a rising edge restarts the ramp |
| out_a | output | 1 | Steered drive output A |
| out_b | output | 1 | Steered drive output B |
| osc_o | output | 1 | Oscillator and blanking pulse; also the sync output |

## Verification
The outputs and `osc_o` come combinationally from registered state and from the override and reset inputs. A change in `ilim_i`, `shdn_i` or `rst` is therefore due in the same cycle. A ramp restart, a sync edge or a new setting first shows one clock edge later, in the first cycle of the new period. The bench drives inputs at the falling edge and samples half a nanosecond later. It advances its own requirement-derived model only at the following rising edge, so every comparison sees the cycle the outputs belong to. Pulse widths are counted over each override-free period that ends by a natural wrap, and compared at that wrap with the arithmetic width from R4.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

   // Steering flip-flop state: which output receives the current period's pulse.
   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   // State the steering flip-flop takes in reset; the first restart flips it to A.
   localparam side_e SIDE_RESET = SIDE_B;

endpackage

// File: rtl/pp_pwm_ramp.sv
// Sawtooth ramp with restart logic and capture of the per-period settings.
module pp_pwm_ramp #(
   parameter int CNT_W   = 8,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] level_i,
   input  logic             sync_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] blk_o,
   output logic [CNT_W-1:0] lvl_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] blk_q;
   logic [CNT_W-1:0] lvl_q;
   logic             sync_edge;

   generate
      if (SYNC_EN) begin : g_sync
         logic sync_d;
         always_ff @(posedge clk) begin
            if (rst) sync_d <= 1'b0;
            else     sync_d <= sync_i;
         end
         assign sync_edge = sync_i & ~sync_d;
      end else begin : g_nosync
         assign sync_edge = 1'b0;
      end
   endgenerate

   assign wrap_o = (cnt_q == per_q) | sync_edge;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         per_q <= '0;
         blk_q <= '0;
         lvl_q <= '0;
      end else if (wrap_o) begin
         cnt_q <= '0;
         per_q <= period_i;
         blk_q <= blank_i;
         lvl_q <= level_i;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign blk_o = blk_q;
   assign lvl_o = lvl_q;

endmodule

// File: rtl/pp_pwm_toggle.sv
// Steering flip-flop advanced by each ramp restart.
module pp_pwm_toggle
   import pp_pwm_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  wrap_i,
   output side_e side_o
);

   side_e side_q;

   always_ff @(posedge clk) begin
      if (rst)         side_q <= SIDE_RESET;
      else if (wrap_i) side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
   end

   assign side_o = side_q;

endmodule

// File: rtl/pp_pwm_gate.sv
// Ramp comparator, blanking window, override latch and output steering.
module pp_pwm_gate
   import pp_pwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] blk_i,
   input  logic [CNT_W-1:0] lvl_i,
   input  side_e            side_i,
   input  logic             wrap_i,
   input  logic             ilim_i,
   input  logic             shdn_i,
   output logic             out_a,
   output logic             out_b,
   output logic             osc_o
);

   localparam int N_SIDES = 2;

   logic               blanking;
   logic               ramp_below;
   logic               override;
   logic               dead_q;
   logic               enable;
   logic [N_SIDES-1:0] drive;

   assign blanking   = cnt_i < blk_i;
   assign ramp_below = cnt_i < lvl_i;
   assign override   = ilim_i | shdn_i;

   // Once an override is seen, the rest of the period stays dark.
   always_ff @(posedge clk) begin
      if (rst)           dead_q <= 1'b0;
      else if (wrap_i)   dead_q <= 1'b0;
      else if (override) dead_q <= 1'b1;
   end

   assign enable = ramp_below & ~blanking & ~override & ~dead_q & ~rst;

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         assign drive[s] = enable & (side_i == ((s == 0) ? SIDE_A : SIDE_B));
      end
   endgenerate

   assign out_a = drive[0];
   assign out_b = drive[1];
   assign osc_o = blanking & ~rst;

endmodule

// File: rtl/pp_pwm_steer.sv
// Top: fixed-frequency push-pull PWM with steering, blanking, override and sync.
module pp_pwm_steer
   import pp_pwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] level_i,
   input  logic             ilim_i,
   input  logic             shdn_i,
   input  logic             sync_i,
   output logic             out_a,
   output logic             out_b,
   output logic             osc_o
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pp_pwm_steer: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] ramp_cnt;
   logic [CNT_W-1:0] ramp_blk;
   logic [CNT_W-1:0] ramp_lvl;
   logic             ramp_wrap;
   side_e            steer_side;

   pp_pwm_ramp #(
      .CNT_W   (CNT_W),
      .SYNC_EN (SYNC_EN)
   ) u_ramp (
      .clk      (clk),
      .rst      (rst),
      .period_i (period_i),
      .blank_i  (blank_i),
      .level_i  (level_i),
      .sync_i   (sync_i),
      .cnt_o    (ramp_cnt),
      .blk_o    (ramp_blk),
      .lvl_o    (ramp_lvl),
      .wrap_o   (ramp_wrap)
   );

   pp_pwm_toggle u_toggle (
      .clk    (clk),
      .rst    (rst),
      .wrap_i (ramp_wrap),
      .side_o (steer_side)
   );

   pp_pwm_gate #(
      .CNT_W (CNT_W)
   ) u_gate (
      .clk    (clk),
      .rst    (rst),
      .cnt_i  (ramp_cnt),
      .blk_i  (ramp_blk),
      .lvl_i  (ramp_lvl),
      .side_i (steer_side),
      .wrap_i (ramp_wrap),
      .ilim_i (ilim_i),
      .shdn_i (shdn_i),
      .out_a  (out_a),
      .out_b  (out_b),
      .osc_o  (osc_o)
   );

endmodule

// File: rtl/pp_pwm_steer_chk.sv
// Property checker attached to every pp_pwm_steer instance.
module pp_pwm_steer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             out_a,
   input logic             out_b,
   input logic             osc_o,
   input logic             ilim_i,
   input logic             shdn_i,
   input logic             sync_i,
   input logic [CNT_W-1:0] cnt,
   input logic             wrap,
   input logic             side
);

   AST_NO_BOTH_ON: assert property (@(posedge clk) disable iff (rst)
      !(out_a && out_b)); // R3

   AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
      osc_o |-> (!out_a && !out_b)); // R3

   AST_OVERRIDE_NOW: assert property (@(posedge clk) disable iff (rst)
      (ilim_i || shdn_i) |-> (!out_a && !out_b)); // R6

   AST_OVERRIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((ilim_i || shdn_i) && !wrap) |=> (!out_a && !out_b)); // R7

   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> (cnt == $past(cnt) + CNT_W'(1))); // R1

   AST_RAMP_RESTART: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt == '0)); // R1

   AST_STEER_FLIP: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (side != $past(side))); // R2

   AST_STEER_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(side)); // R2

   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_i) |=> (cnt == '0)); // R8

   always_comb begin
      if (rst) begin
         AST_RESET_QUIET: assert (!out_a && !out_b && !osc_o); // R9
      end
   end

endmodule

bind pp_pwm_steer pp_pwm_steer_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .out_a  (out_a),
   .out_b  (out_b),
   .osc_o  (osc_o),
   .ilim_i (ilim_i),
   .shdn_i (shdn_i),
   .sync_i (sync_i),
   .cnt    (ramp_cnt),
   .wrap   (ramp_wrap),
   .side   (steer_side)
);

// File: tb/pp_pwm_steer_tb.sv
`timescale 1ns/1ps
module pp_pwm_steer_tb;

   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst    = 1'b1;
   logic [W-1:0] per_r  = '0;
   logic [W-1:0] blk_r  = '0;
   logic [W-1:0] lvl_r  = '0;
   logic         ilim_r = 1'b0;
   logic         shdn_r = 1'b0;
   logic         sync_r = 1'b0;
   logic         out_a, out_b, osc_o;

   pp_pwm_steer #(.CNT_W(W)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .period_i (per_r),
      .blank_i  (blk_r),
      .level_i  (lvl_r),
      .ilim_i   (ilim_r),
      .shdn_i   (shdn_r),
      .sync_i   (sync_r),
      .out_a    (out_a),
      .out_b    (out_b),
      .osc_o    (osc_o)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string tag    = "R9";

   // Requirement model state.
   int m_cnt, m_per, m_blk, m_lvl, m_hi;
   bit m_side, m_kill, m_syncd, m_clean;

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare the outputs of the current cycle with the model.
   task automatic sample();
      bit ov, osc, raw, ea, eb;
      ov  = ilim_r | shdn_r;
      osc = !rst && (m_cnt < m_blk);
      raw = (m_cnt >= m_blk) && (m_cnt < m_lvl);
      ea  = raw && !m_side && !m_kill && !ov && !rst;
      eb  = raw &&  m_side && !m_kill && !ov && !rst;
      check_eq("R1", "osc_o", int'(osc_o), int'(osc));
      check_eq(tag, "out_a", int'(out_a), int'(ea));
      check_eq(tag, "out_b", int'(out_b), int'(eb));
      check_eq("R3", "both_high", int'(out_a && out_b), 0);
      if (out_a || out_b) m_hi++;
      if (ov) m_clean = 1'b0;
   endtask

   // Advance the model at a rising edge.
   task automatic model_update();
      bit edge_s, nat;
      int exp_w, top;
      if (rst) begin
         m_cnt = 0; m_per = 0; m_blk = 0; m_lvl = 0;
         m_side = 1'b1; m_kill = 1'b0; m_syncd = 1'b0;
         m_hi = 0; m_clean = 1'b0;
      end else begin
         edge_s  = sync_r && !m_syncd;
         m_syncd = sync_r;
         nat     = (m_cnt == m_per);
         if (nat || edge_s) begin
            if (nat && !edge_s && m_clean) begin
               top   = (m_lvl < m_per + 1) ? m_lvl : m_per + 1;
               exp_w = (m_lvl > m_blk) ? top - m_blk : 0;
               check_eq("R4", "pulse_width", m_hi, exp_w);
            end
            m_cnt = 0; m_per = int'(per_r); m_blk = int'(blk_r); m_lvl = int'(lvl_r);
            m_side = !m_side; m_kill = 1'b0; m_hi = 0; m_clean = 1'b1;
         end else begin
            m_cnt++;
            if (ilim_r || shdn_r) m_kill = 1'b1;
         end
      end
   endtask

   task automatic step();
      #0.5;
      sample();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      @(posedge clk);
      model_update();
      @(negedge clk);

      // R9: outputs quiet while reset is held, settings present on inputs.
      tag = "R9";
      per_r = 8'd5; blk_r = 8'd1; lvl_r = 8'd4;
      repeat (3) step();
      rst = 1'b0;

      // R2 alternation with R1 ramp, R3 blanking and R4 widths over a sweep.
      tag = "R2";
      for (int p = 3; p <= 7; p++) begin
         for (int b = 0; b <= 3; b++) begin
            for (int l = 0; l <= p + 2; l++) begin
               per_r = W'(p); blk_r = W'(b); lvl_r = W'(l);
               repeat (24) step();
            end
         end
      end

      // R5: settings move every cycle; only restart-time values count.
      tag = "R5";
      per_r = 8'd9; blk_r = 8'd2; lvl_r = 8'd6;
      repeat (20) step();
      for (int k = 0; k < 60; k++) begin
         lvl_r = W'(k % 11);
         per_r = W'(8 + (k % 3));
         blk_r = W'(k % 4);
         step();
      end

      // R6: current-limit pulses at varying ramp positions.
      tag = "R6";
      per_r = 8'd12; blk_r = 8'd1; lvl_r = 8'd12;
      for (int k = 0; k < 90; k++) begin
         ilim_r = ((k % 9) == 4);
         step();
      end
      ilim_r = 1'b0;

      // R7: single-cycle shutdown mid-pulse, output stays dark to the restart.
      tag = "R7";
      for (int k = 0; k < 90; k++) begin
         shdn_r = ((k % 23) == 10) || ((k % 31) == 5);
         step();
      end
      shdn_r = 1'b0;
      repeat (30) step();

      // R8: external sync with a shorter period than the local one.
      tag = "R8";
      per_r = 8'd30; blk_r = 8'd2; lvl_r = 8'd12;
      for (int k = 0; k < 140; k++) begin
         sync_r = (k > 10) && ((k % 17) < 3);
         step();
      end
      sync_r = 1'b0;
      repeat (40) step();

      // R9: reset in mid-run, then restart from the reset state.
      tag = "R9";
      per_r = 8'd6; blk_r = 8'd1; lvl_r = 8'd7;
      repeat (10) step();
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      repeat (20) step();

      finish_run();
   end

endmodule